// File: doc/BRIEF.md
# Octant-Folding Oscillator Phase Path

This block is the phase side of a numerically controlled oscillator. A frequency word held in a register is added to an 18-bit phase accumulator on every clock. Each phase value is split into a 3-bit octant code and a residual. The residual is mirrored in odd octants and scaled into radians with shifts and adds. The resulting first-octant angle goes out to an external sine/cosine core.

The block does not contain that core. The core must return its cosine and sine a fixed `CORE_LAT` cycles after it receives an angle. The block delays the octant code by the same amount. When the results come back, it uses the delayed code to swap and negate them, which rebuilds cosine and sine over the full circle. It then presents them as signed 16-bit values with a valid flag.

A frequency word F gives an output frequency of F·fclk/2^18, so the tuning step is fclk/2^18.

Top module: `nco_octant_fold`

## Requirements
- R1: When `rst_n` is low, the frequency register, the phase accumulator, `core_angle`, `cos_out`, `sin_out` and `valid_out` are all zero.
- R2: `fcw_in` is written into the frequency register only on a clock edge where `load` is high. At all other edges, changes on `fcw_in` have no effect on the phase sequence.
- R3: At every clock edge after reset, the phase becomes (phase + frequency register) mod 2^18. The add uses the register value from before that edge.
- R4: The octant is phase[17:15] and the residual r is phase[14:0]. In even octants the folded value is f = r. In odd octants it is f = 32768 − r, so f ranges over 0..32768.
- R5: `core_angle` is unsigned with an LSB of 2^-16 rad. Its value is f + (f>>1) + (f>>4) + (f>>7) + (f>>11), with each shifted term truncated. This is f·π/2 built without a multiplier, and it never exceeds 51472.
- R6: `core_angle` is registered one clock after the phase value it comes from. The core results on `core_cos`/`core_sin` are expected `CORE_LAT` clocks after that. `cos_out`/`sin_out` are registered one clock after the results arrive.
- R7: With core results C and S and octant o, the outputs (cos, sin) are:
  - o=0: (C, S)
  - o=1: (S, C)
  - o=2: (−S, C)
  - o=3: (−C, S)
  - o=4: (−C, −S)
  - o=5: (−S, −C)
  - o=6: (S, −C)
  - o=7: (C, −S)
- R8: Negating −32768 gives +32767. Every other value negates exactly.
- R9: `valid_out` first goes high on clock edge `CORE_LAT`+2 after reset release. It stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Write `fcw_in` into the frequency register |
| fcw_in | input | 18 | Frequency control word |
| core_angle | output | 16 | First-octant angle sent to the core, LSB 2^-16 rad |
| core_cos | input | 16 | Core cosine result, signed |
| core_sin | input | 16 | Core sine result, signed |
| cos_out | output | 16 | Full-circle cosine, signed |
| sin_out | output | 16 | Full-circle sine, signed |
| valid_out | output | 1 | Outputs carry a result |

## Verification
The bench steps its own phase model in step with each rising edge, using the `load` and `fcw_in` it drives.

- **Angle check:** a phase value that is current before edge e must appear on `core_angle` after edge e. It is compared at the next falling edge.
- **Output check:** the octant-mapped result for that same phase goes into a queue. It must reach `cos_out`/`sin_out` after edge e+`CORE_LAT`+1. A monitor pops one entry at every falling edge where `valid_out` is high, so each output is compared against the item due in that cycle.
- **Valid timing:** the first rise of `valid_out` is checked at the falling edges around edge `CORE_LAT`+2.

A stand-in core in the bench maps angle 0 to −32768 so that saturation can be exercised.

// File: rtl/nco_octant_fold.sv
module nco_octant_fold #(
  parameter int PHASE_W  = 18,
  parameter int AMP_W    = 16,
  parameter int CORE_LAT = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [PHASE_W-1:0]       fcw_in,
  output logic [PHASE_W-3:0]       core_angle,
  input  logic signed [AMP_W-1:0]  core_cos,
  input  logic signed [AMP_W-1:0]  core_sin,
  output logic signed [AMP_W-1:0]  cos_out,
  output logic signed [AMP_W-1:0]  sin_out,
  output logic                     valid_out
);
  localparam int RES_W = PHASE_W - 3;
  localparam logic [RES_W:0] EIGHTH = (RES_W+1)'(1) << RES_W;
  localparam logic [RES_W:0] ANG_MAX = EIGHTH + (EIGHTH >> 1) + (EIGHTH >> 4)
                                     + (EIGHTH >> 7) + (EIGHTH >> 11);
  localparam logic signed [AMP_W-1:0] AMP_MIN = {1'b1, {(AMP_W-1){1'b0}}};
  localparam logic signed [AMP_W-1:0] AMP_MAX = {1'b0, {(AMP_W-1){1'b1}}};

  logic [PHASE_W-1:0] fcw_q, phase_q;
  logic [2:0]         oct_pipe [0:CORE_LAT];
  logic [CORE_LAT:0]  vpipe;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fcw_q   <= '0;
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + fcw_q;
      if (load) fcw_q <= fcw_in;
    end

  wire [2:0]       oct = phase_q[PHASE_W-1 -: 3];
  wire [RES_W-1:0] res = phase_q[RES_W-1:0];
  wire [RES_W:0]   fold = oct[0] ? EIGHTH - {1'b0, res} : {1'b0, res};
  wire [RES_W:0]   scaled = fold + (fold >> 1) + (fold >> 4) + (fold >> 7) + (fold >> 11);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      core_angle <= '0;
      vpipe      <= '0;
      for (int i = 0; i <= CORE_LAT; i++) oct_pipe[i] <= '0;
    end else begin
      core_angle  <= scaled;
      vpipe       <= {vpipe[CORE_LAT-1:0], 1'b1};
      oct_pipe[0] <= oct;
      for (int i = 1; i <= CORE_LAT; i++) oct_pipe[i] <= oct_pipe[i-1];
    end

  wire [2:0] ot   = oct_pipe[CORE_LAT];
  wire       swap = ot[1] ^ ot[0];
  wire       xinv = ot[2] ^ ot[1];
  wire       yinv = ot[2];

  wire signed [AMP_W-1:0] pre_c = swap ? core_sin : core_cos;
  wire signed [AMP_W-1:0] pre_s = swap ? core_cos : core_sin;

  function automatic logic signed [AMP_W-1:0] sat_neg(input logic signed [AMP_W-1:0] v);
    return (v == AMP_MIN) ? AMP_MAX : -v;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cos_out   <= '0;
      sin_out   <= '0;
      valid_out <= 1'b0;
    end else begin
      cos_out   <= xinv ? sat_neg(pre_c) : pre_c;
      sin_out   <= yinv ? sat_neg(pre_s) : pre_s;
      valid_out <= vpipe[CORE_LAT];
    end

  p_fcw_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(fcw_q));
  p_fcw_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> fcw_q == $past(fcw_in));
  p_angle_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, core_angle} <= ANG_MAX);
  p_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ot == 3'b000 |=> (cos_out == $past(core_cos) && sin_out == $past(core_sin)));
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!swap && xinv && core_cos == AMP_MIN) |=> cos_out == AMP_MAX);
  p_valid_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_out |=> valid_out);
endmodule

// File: tb/nco_octant_fold_tb.sv
module nco_octant_fold_tb;
  localparam int CL = 4;

  logic clk = 0, rst_n = 0, load = 0;
  logic [17:0] fcw_in = '0;
  logic [15:0] core_angle;
  logic signed [15:0] core_cos, core_sin, cos_out, sin_out;
  logic valid_out;
  int checks = 0, fails = 0;
  string tag = "R1";
  bit done = 0;

  always #4 clk = ~clk;

  nco_octant_fold #(.CORE_LAT(CL)) u_dut (
    .clk(clk), .rst_n(rst_n), .load(load), .fcw_in(fcw_in),
    .core_angle(core_angle), .core_cos(core_cos), .core_sin(core_sin),
    .cos_out(cos_out), .sin_out(sin_out), .valid_out(valid_out));

  // stand-in core: CL clocks of latency, angle 0 yields the most negative code
  logic [15:0] cpipe [0:CL-1];
  always @(posedge clk) begin
    cpipe[0] <= core_angle;
    for (int i = 1; i < CL; i++) cpipe[i] <= cpipe[i-1];
  end

  function automatic logic signed [15:0] mc(input logic [15:0] a);
    return (a == 0) ? 16'sh8000 : signed'(a);
  endfunction
  function automatic logic signed [15:0] ms(input logic [15:0] a);
    return (a == 0) ? 16'sh8000 : signed'(~a);
  endfunction

  assign core_cos = mc(cpipe[CL-1]);
  assign core_sin = ms(cpipe[CL-1]);

  function automatic logic signed [15:0] neg(input logic signed [15:0] v);
    return (v == -16'sd32768) ? 16'sd32767 : -v;
  endfunction

  // R4 R5: fold and scale
  function automatic logic [15:0] ang_of(input logic [17:0] p);
    int r, f;
    r = int'(p[14:0]);
    f = p[15] ? 32768 - r : r;
    return 16'(f + (f >> 1) + (f >> 4) + (f >> 7) + (f >> 11));
  endfunction

  // R7 R8: octant table
  function automatic logic [31:0] exp_of(input logic [17:0] p);
    logic signed [15:0] c, s, oc, os;
    c = mc(ang_of(p));
    s = ms(ang_of(p));
    case (p[17:15])
      3'd0: begin oc = c;      os = s;      end
      3'd1: begin oc = s;      os = c;      end
      3'd2: begin oc = neg(s); os = c;      end
      3'd3: begin oc = neg(c); os = s;      end
      3'd4: begin oc = neg(c); os = neg(s); end
      3'd5: begin oc = neg(s); os = neg(c); end
      3'd6: begin oc = s;      os = neg(c); end
      default: begin oc = c;   os = neg(s); end
    endcase
    return {oc, os};
  endfunction

  // reference model: R2 R3 phase and word register
  logic [31:0] q [$];
  logic [17:0] mp, mf;
  logic [15:0] exp_ang;
  bit have_ang = 0;

  always @(posedge clk)
    if (!rst_n) begin
      mp = 0; mf = 0; q.delete(); have_ang = 0;
    end else begin
      exp_ang = ang_of(mp);
      have_ang = 1;
      q.push_back(exp_of(mp));
      mp = mp + mf;
      if (load) mf = fcw_in;
    end

  task automatic chk(input bit ok, input string t, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  // monitor: R6 timing through queue order
  always @(negedge clk)
    if (rst_n && !done) begin
      if (have_ang) chk(core_angle == exp_ang, "R5 core_angle", core_angle, exp_ang);
      if (valid_out) begin
        if (q.size() == 0) chk(0, "R6 output without expected item", 1, 0);
        else begin
          logic [31:0] e;
          e = q.pop_front();
          chk(cos_out == signed'(e[31:16]), {tag, " cos"}, cos_out, signed'(e[31:16]));
          chk(sin_out == signed'(e[15:0]),  {tag, " sin"}, sin_out, signed'(e[15:0]));
        end
      end
    end

  task automatic drive(input int n, input bit ld, input logic [17:0] f);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      load = ld;
      fcw_in = f;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; load = 0;
    repeat (2) @(negedge clk);
    tag = "R1";
    chk(valid_out == 0, "R1 valid", valid_out, 0);
    chk(cos_out == 0 && sin_out == 0, "R1 outputs", cos_out, 0);
    chk(core_angle == 0, "R1 angle", core_angle, 0);
    rst_n = 1;
  endtask

  initial begin
    do_reset();
    // R9: first valid at edge CL+2 after release
    drive(1, 1, 18'h01234);
    tag = "R3";
    drive(CL + 3, 0, 18'h01234);
    drive(220, 0, 18'h01234);
    tag = "R2";
    for (int i = 0; i < 60; i++) drive(1, 0, 18'(i * 977 + 5));
    tag = "R8";
    do_reset();
    drive(1, 1, 18'h20000);
    drive(30, 0, 18'h0);
    tag = "R4";
    do_reset();
    drive(1, 1, 18'h08000);
    drive(40, 0, 18'h0);
    tag = "R3";
    drive(1, 1, 18'h3FFFF);
    drive(120, 0, 18'h3FFFF);
    tag = "R7";
    drive(1, 1, 18'h0AB3D);
    drive(120, 0, 18'h0AB3D);
    repeat (CL + 4) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  // R9 valid rise timing, checked right after each reset release
  initial begin
    forever begin
      @(posedge rst_n);
      repeat (CL + 1) @(posedge clk);
      @(negedge clk);
      chk(valid_out == 0, "R9 valid early", valid_out, 0);
      @(negedge clk);
      chk(valid_out == 1, "R9 valid rise", valid_out, 1);
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule